// File: doc/BRIEF.md
# Sound Subsystem Priority-Level Interrupt Controller

This block gathers eleven interrupt causes from a sound-processing subsystem and turns them into a single 3-bit priority level for the host processor's auto-vector input. The causes are three active-low external lines, the receive and transmit FIFO status of a serial music interface, a DMA completion pulse, a software-triggered request, three timer pulses and a per-audio-sample strobe. The timers, DMA engine, FIFOs and processor live elsewhere. Only their status lines and pulses reach this block.

Software uses a small register bus to reach the enable mask, the pending view, the acknowledge register and three level slice registers. Each source's 3-bit level code is split across the three slices, one code bit per slice, at the column of that source. The four highest sources share one column. Pulse-type causes are held in a latch until acknowledged. The two FIFO causes follow the live FIFO state and need no acknowledgement. The output is the highest level among enabled pending sources.

Top module: `snd_irq_level_ctrl`

## Requirements
- R1: After reset the enable mask, latched pending bits and all three level slices are zero, and `irq_level` is 0.
- R2: Pending bits 0, 1 and 2 are set by a falling edge on `ext_irq_n[0..2]`. A line held low does not set its bit again after acknowledgement.
- R3: Pending bit 3 equals `midi_in_ne` (receive FIFO not empty) in the same cycle. Writing the acknowledge register does not change it.
- R4: Pending bit 9 equals `midi_out_empty` (transmit FIFO empty) in the same cycle. Writing the acknowledge register does not change it.
- R5: A one-cycle pulse latches pending bit 4 on `dma_done`, bits 6, 7 and 8 on `tmr_pulse[0..2]`, and bit 10 on `smp_tick`.
- R6: A write to address 1 with data bit 5 set latches pending bit 5. A write with bit 5 clear changes nothing, and the other data bits of that write are ignored.
- R7: Writing address 2 clears each latched pending bit whose data bit is 1. A set arriving in the same cycle wins. Address 2 reads as zero.
- R8: Addresses 3, 4 and 5 hold bits 0, 1 and 2 of the level codes in data bits 7:0, one column per bit. Source i uses column i for i below 7. Sources 7 to 10 all use column 7.
- R9: A source whose level code is 000 never contributes to `irq_level`, even when pending and enabled.
- R10: `irq_level` takes, one clock after the pending and enable state, the largest level code among sources that are pending and enabled, or 0 if none are.
- R11: Address 0 is the enable mask with source i at bit i. Bits 15 to 11 of the enable and pending reads are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| ext_irq_n | input | 3 | External interrupt lines, active low, edge sensitive |
| midi_in_ne | input | 1 | Receive FIFO holds data |
| midi_out_empty | input | 1 | Transmit FIFO is empty |
| dma_done | input | 1 | DMA transfer complete pulse |
| tmr_pulse | input | 3 | Timer A, B and C expiry pulses |
| smp_tick | input | 1 | Once-per-audio-sample strobe |
| irq_level | output | 3 | Auto-vector priority level, 0 means no request |

## Verification
A pulse or falling edge present at clock edge k shows as pending in the read data just after edge k. The matching level appears on `irq_level` after edge k+1. The FIFO status bits appear in the pending read as soon as the line changes and reach `irq_level` at the next edge. Register writes take effect at their write edge and read back straight away. The bench drives stimulus on falling edges. It updates a behavioural model at each rising edge and compares `bus_rdata` and `irq_level` with the model 1 ns after every rising edge, so each result is sampled in the cycle it is due.

// File: rtl/sndirq_pkg.sv
package sndirq_pkg;

   localparam int NUM_SRC    = 11;
   localparam int SHARED_COL = 7;

   // source positions that the level decode and software depend on
   localparam int SRC_EXT0     = 0;
   localparam int SRC_MIDI_IN  = 3;
   localparam int SRC_DMA      = 4;
   localparam int SRC_MANUAL   = 5;
   localparam int SRC_TMR0     = 6;
   localparam int SRC_MIDI_OUT = 9;
   localparam int SRC_TICK     = 10;

   // register addresses
   localparam int ADR_ENABLE = 0;
   localparam int ADR_PEND   = 1;
   localparam int ADR_ACK    = 2;
   localparam int ADR_SLICE0 = 3;

   function automatic int col_of(input int src);
      return (src < SHARED_COL) ? src : SHARED_COL;
   endfunction

endpackage

// File: rtl/irq_src_pending.sv
module irq_src_pending
   import sndirq_pkg::*;
#(
   parameter int NUM_EXT = 3,
   parameter int NUM_TMR = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_n_i,
   input  logic               midi_in_ne_i,
   input  logic               midi_out_empty_i,
   input  logic               dma_done_i,
   input  logic [NUM_TMR-1:0] tmr_i,
   input  logic               tick_i,
   input  logic               man_set_i,
   input  logic [NUM_SRC-1:0] ack_i,
   output logic [NUM_SRC-1:0] pend_o
);

   logic [NUM_EXT-1:0] ext_prev_q;
   logic [NUM_EXT-1:0] ext_fall;
   logic [NUM_SRC-1:0] set_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev_q <= '1;
      else        ext_prev_q <= ext_n_i;
   end

   assign ext_fall = ext_prev_q & ~ext_n_i;

   always_comb begin
      set_vec                      = '0;
      set_vec[SRC_EXT0 +: NUM_EXT] = ext_fall;
      set_vec[SRC_DMA]             = dma_done_i;
      set_vec[SRC_MANUAL]          = man_set_i;
      set_vec[SRC_TMR0 +: NUM_TMR] = tmr_i;
      set_vec[SRC_TICK]            = tick_i;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i == SRC_MIDI_IN) begin : g_rx
         logic unused_rx;
         assign unused_rx = set_vec[i] ^ ack_i[i];
         assign pend_o[i] = midi_in_ne_i;
      end else if (i == SRC_MIDI_OUT) begin : g_tx
         logic unused_tx;
         assign unused_tx = set_vec[i] ^ ack_i[i];
         assign pend_o[i] = midi_out_empty_i;
      end else begin : g_lat
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          hold_q <= 1'b0;
            else if (set_vec[i]) hold_q <= 1'b1;
            else if (ack_i[i])   hold_q <= 1'b0;
         end
         assign pend_o[i] = hold_q;
      end
   end

endmodule

// File: rtl/irq_lvl_bank.sv
module irq_lvl_bank
   import sndirq_pkg::*;
#(
   parameter int LVL_W    = 3,
   parameter int NUM_COLS = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [LVL_W-1:0]                    wr_sel_i,
   input  logic [NUM_COLS-1:0]                 wr_bits_i,
   output logic [LVL_W-1:0][NUM_COLS-1:0]      slice_o,
   output logic [NUM_SRC-1:0][LVL_W-1:0]       src_lvl_o
);

   for (genvar k = 0; k < LVL_W; k++) begin : g_slice
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           slice_o[k] <= '0;
         else if (wr_sel_i[k]) slice_o[k] <= wr_bits_i;
      end
   end

   // gather one bit per slice at the source's column
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_col
      localparam int COL = col_of(i);
      for (genvar k = 0; k < LVL_W; k++) begin : g_bit
         assign src_lvl_o[i][k] = slice_o[k][COL];
      end
   end

endmodule

// File: rtl/irq_lvl_max.sv
module irq_lvl_max
   import sndirq_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic [NUM_SRC-1:0]            req_i,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
   output logic [LVL_W-1:0]              max_o
);

   always_comb begin
      max_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (lvl_i[i] > max_o)) max_o = lvl_i[i];
      end
   end

endmodule

// File: rtl/snd_irq_level_ctrl.sv
module snd_irq_level_ctrl
   import sndirq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 3,
   parameter int LVL_W    = 3,
   parameter int NUM_COLS = 8,
   parameter int NUM_EXT  = 3,
   parameter int NUM_TMR  = 3,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_EXT-1:0] ext_irq_n,
   input  logic               midi_in_ne,
   input  logic               midi_out_empty,
   input  logic               dma_done,
   input  logic [NUM_TMR-1:0] tmr_pulse,
   input  logic               smp_tick,
   output logic [LVL_W-1:0]   irq_level
);

   localparam int TOP_REG = ADR_SLICE0 + LVL_W;

   initial begin : p_param_chk
      assert (DATA_W >= NUM_SRC)          else $fatal(1, "data bus narrower than source count");
      assert (DATA_W >= NUM_COLS)         else $fatal(1, "data bus narrower than column count");
      assert (NUM_COLS == SHARED_COL + 1) else $fatal(1, "column count must end at shared column");
      assert (TOP_REG <= (1 << ADDR_W))   else $fatal(1, "address space too small");
      assert (NUM_EXT == SRC_MIDI_IN - SRC_EXT0) else $fatal(1, "external count breaks layout");
      assert (NUM_TMR == SRC_MIDI_OUT - SRC_TMR0) else $fatal(1, "timer count breaks layout");
   end

   logic [NUM_SRC-1:0]             en_q;
   logic [NUM_SRC-1:0]             pend;
   logic [NUM_SRC-1:0]             ack_mask;
   logic                           man_set;
   logic [LVL_W-1:0]               slice_sel;
   logic [LVL_W-1:0][NUM_COLS-1:0] slice_q;
   logic [NUM_SRC-1:0][LVL_W-1:0]  src_lvl;
   logic [LVL_W-1:0]               lvl_max;
   logic                           unused_hi;

   assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

   // bus decode
   assign man_set  = bus_wr && (bus_addr == ADDR_W'(ADR_PEND)) && bus_wdata[SRC_MANUAL];
   assign ack_mask = (bus_wr && (bus_addr == ADDR_W'(ADR_ACK))) ? bus_wdata[NUM_SRC-1:0] : '0;

   for (genvar k = 0; k < LVL_W; k++) begin : g_sel
      assign slice_sel[k] = bus_wr && (bus_addr == ADDR_W'(ADR_SLICE0 + k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else if (bus_wr && (bus_addr == ADDR_W'(ADR_ENABLE))) en_q <= bus_wdata[NUM_SRC-1:0];
   end

   irq_src_pending #(
      .NUM_EXT (NUM_EXT),
      .NUM_TMR (NUM_TMR)
   ) u_pend (
      .clk              (clk),
      .rst_n            (rst_n),
      .ext_n_i          (ext_irq_n),
      .midi_in_ne_i     (midi_in_ne),
      .midi_out_empty_i (midi_out_empty),
      .dma_done_i       (dma_done),
      .tmr_i            (tmr_pulse),
      .tick_i           (smp_tick),
      .man_set_i        (man_set),
      .ack_i            (ack_mask),
      .pend_o           (pend)
   );

   irq_lvl_bank #(
      .LVL_W    (LVL_W),
      .NUM_COLS (NUM_COLS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel_i  (slice_sel),
      .wr_bits_i (bus_wdata[NUM_COLS-1:0]),
      .slice_o   (slice_q),
      .src_lvl_o (src_lvl)
   );

   irq_lvl_max #(
      .LVL_W (LVL_W)
   ) u_max (
      .req_i (pend & en_q),
      .lvl_i (src_lvl),
      .max_o (lvl_max)
   );

   // output stage variant
   if (REG_OUT) begin : g_oreg
      logic [LVL_W-1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= '0;
         else        lvl_q <= lvl_max;
      end
      assign irq_level = lvl_q;
   end else begin : g_ocomb
      assign irq_level = lvl_max;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_ENABLE)) bus_rdata[NUM_SRC-1:0] = en_q;
      if (bus_addr == ADDR_W'(ADR_PEND))   bus_rdata[NUM_SRC-1:0] = pend;
      for (int k = 0; k < LVL_W; k++) begin
         if (bus_addr == ADDR_W'(ADR_SLICE0 + k)) bus_rdata[NUM_COLS-1:0] = slice_q[k];
      end
   end

endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk
   import sndirq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter int LVL_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               dma_done,
   input logic               midi_out_empty,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] en_q,
   input logic [LVL_W-1:0]   irq_level
);

   // R6
   man_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(ADR_PEND) && bus_wdata[SRC_MANUAL]) |=> pend[SRC_MANUAL]);

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(ADR_ACK) && bus_wdata[SRC_DMA] && !dma_done) |=> !pend[SRC_DMA]);

   // R4
   tx_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[SRC_MIDI_OUT] == midi_out_empty);

   // R10
   level_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> $past((pend & en_q) != '0));

   // R11
   hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:NUM_SRC] == '0);

   // R1
   reset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_level == '0));

endmodule

bind snd_irq_level_ctrl irq_level_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .LVL_W  (LVL_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_wr         (bus_wr),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .dma_done       (dma_done),
   .midi_out_empty (midi_out_empty),
   .pend           (pend),
   .en_q           (en_q),
   .irq_level      (irq_level)
);

// File: tb/sim_snd_irq_level_ctrl.sv
`timescale 1ns/1ps
module sim_snd_irq_level_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd1;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  ext_irq_n = 3'b111;
   logic        midi_in_ne = 1'b0;
   logic        midi_out_empty = 1'b0;
   logic        dma_done = 1'b0;
   logic [2:0]  tmr_pulse = '0;
   logic        smp_tick = 1'b0;
   logic [2:0]  irq_level;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   bit    chk_on = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   snd_irq_level_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_irq_n(ext_irq_n),
      .midi_in_ne(midi_in_ne), .midi_out_empty(midi_out_empty),
      .dma_done(dma_done), .tmr_pulse(tmr_pulse), .smp_tick(smp_tick),
      .irq_level(irq_level)
   );

   // behavioural reference model
   logic [10:0] m_en, m_lat;
   logic [7:0]  m_lvl [3];
   logic [2:0]  m_prev, m_out;
   localparam logic [10:0] LAT_MASK = 11'h5F7; // all but bits 3 and 9

   function automatic logic [10:0] m_full();
      logic [10:0] f;
      f = m_lat;
      f[3] = midi_in_ne;
      f[9] = midi_out_empty;
      return f;
   endfunction

   function automatic logic [15:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {5'd0, m_en};
         3'd1: return {5'd0, m_full()};
         3'd3: return {8'd0, m_lvl[0]};
         3'd4: return {8'd0, m_lvl[1]};
         3'd5: return {8'd0, m_lvl[2]};
         default: return 16'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_lat = '0; m_prev = 3'b111; m_out = '0;
         for (int k = 0; k < 3; k++) m_lvl[k] = '0;
      end else begin
         logic [10:0] full, set, ack;
         logic [2:0]  mx, code;
         int          c;
         full = m_full();
         mx = '0;
         for (int i = 0; i < 11; i++) begin
            c = (i < 7) ? i : 7;
            code = {m_lvl[2][c], m_lvl[1][c], m_lvl[0][c]};
            if (full[i] && m_en[i] && code > mx) mx = code;
         end
         set = '0;
         set[2:0]  = m_prev & ~ext_irq_n;
         set[4]    = dma_done;
         set[5]    = bus_wr && bus_addr == 3'd1 && bus_wdata[5];
         set[8:6]  = tmr_pulse;
         set[10]   = smp_tick;
         ack = (bus_wr && bus_addr == 3'd2) ? bus_wdata[10:0] : '0;
         m_lat  = ((m_lat & ~ack) | set) & LAT_MASK;
         m_prev = ext_irq_n;
         if (bus_wr && bus_addr == 3'd0) m_en = bus_wdata[10:0];
         for (int k = 0; k < 3; k++)
            if (bus_wr && bus_addr == 3'(3 + k)) m_lvl[k] = bus_wdata[7:0];
         m_out = mx;
      end
   end

   task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (chk_on && rst_n) begin
         check(cur_req, "rdata", bus_rdata, m_read(bus_addr));
         check(cur_req, "irq_level", {13'd0, irq_level}, {13'd0, m_out});
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bw(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 3'd1; bus_wdata = '0;
   endtask

   task automatic set_codes(input logic [2:0] codes [8]);
      for (int k = 0; k < 3; k++) begin
         logic [15:0] d;
         d = '0;
         for (int c = 0; c < 8; c++) d[c] = codes[c][k];
         bw(3'(3 + k), d);
         bus_addr = 3'(3 + k);
         idle(1);
      end
      bus_addr = 3'd1;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [2:0] codes [8];
      idle(3);
      // R1: reset state visible on every address
      for (int a = 0; a < 8; a++) begin
         bus_addr = 3'(a);
         #1;
         check("R1", "reset rdata", bus_rdata, 16'd0);
         check("R1", "reset level", {13'd0, irq_level}, 16'd0);
      end
      bus_addr = 3'd1;
      @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1;
      idle(2);

      // R8: program sliced codes, column c gets c+1, shared column gets 2
      cur_req = "R8";
      for (int c = 0; c < 7; c++) codes[c] = 3'(c + 1);
      codes[7] = 3'd2;
      set_codes(codes);

      // R11: enable mask, upper bits dropped
      cur_req = "R11";
      bw(3'd0, 16'hFFFF);
      bus_addr = 3'd0; idle(2); bus_addr = 3'd1;

      // R2: falling edges, held low does not retrigger after ack
      cur_req = "R2";
      @(negedge clk); ext_irq_n[1] = 1'b0;
      idle(3);
      bw(3'd2, 16'h0002);
      idle(3);
      @(negedge clk); ext_irq_n[1] = 1'b1; ext_irq_n[0] = 1'b0;
      idle(2);
      @(negedge clk); ext_irq_n = 3'b011;
      idle(2);
      bw(3'd2, 16'h0007);
      @(negedge clk); ext_irq_n = 3'b111;
      idle(2);

      // R3: receive FIFO status is live, ack ignored
      cur_req = "R3";
      @(negedge clk); midi_in_ne = 1'b1;
      idle(2);
      bw(3'd2, 16'h0008);
      idle(2);
      @(negedge clk); midi_in_ne = 1'b0;
      idle(2);

      // R4: transmit FIFO empty is live, ack ignored
      cur_req = "R4";
      @(negedge clk); midi_out_empty = 1'b1;
      idle(2);
      bw(3'd2, 16'h0200);
      idle(2);
      @(negedge clk); midi_out_empty = 1'b0;
      idle(2);

      // R5: pulse sources latch
      cur_req = "R5";
      @(negedge clk); dma_done = 1'b1;
      @(negedge clk); dma_done = 1'b0;
      idle(2);
      for (int t = 0; t < 3; t++) begin
         @(negedge clk); tmr_pulse[t] = 1'b1;
         @(negedge clk); tmr_pulse[t] = 1'b0;
         idle(2);
      end
      @(negedge clk); smp_tick = 1'b1;
      @(negedge clk); smp_tick = 1'b0;
      idle(2);
      bw(3'd2, 16'hFFFF);
      idle(2);

      // R6: manual request, only bit 5 at address 1 matters
      cur_req = "R6";
      bw(3'd1, 16'h0000);
      idle(2);
      bw(3'd1, 16'hFFDF);
      idle(2);
      bw(3'd1, 16'h0020);
      idle(2);
      bw(3'd2, 16'h0020);
      idle(2);

      // R7: set beats simultaneous ack, address 2 reads zero
      cur_req = "R7";
      @(negedge clk);
      dma_done = 1'b1; bus_addr = 3'd2; bus_wdata = 16'h0010; bus_wr = 1'b1;
      @(negedge clk);
      dma_done = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      idle(1);
      bus_addr = 3'd1;
      idle(2);
      bw(3'd2, 16'h0010);
      idle(2);

      // R9: code 000 never raises the output
      cur_req = "R9";
      for (int c = 0; c < 8; c++) codes[c] = 3'd0;
      codes[4] = 3'd3;
      set_codes(codes);
      @(negedge clk); tmr_pulse[0] = 1'b1;
      @(negedge clk); tmr_pulse[0] = 1'b0;
      idle(3);
      bw(3'd2, 16'h0040);
      idle(2);

      // R10: maximum over pending and enabled, enable changes
      cur_req = "R10";
      for (int c = 0; c < 7; c++) codes[c] = 3'(7 - c);
      codes[7] = 3'd5;
      set_codes(codes);
      @(negedge clk); dma_done = 1'b1; smp_tick = 1'b1; ext_irq_n[2] = 1'b0;
      @(negedge clk); dma_done = 1'b0; smp_tick = 1'b0;
      idle(2);
      bw(3'd0, 16'h0410);
      idle(2);
      bw(3'd0, 16'h0010);
      idle(2);
      bw(3'd0, 16'h0000);
      idle(2);
      bw(3'd0, 16'h07FF);
      @(negedge clk); midi_out_empty = 1'b1; ext_irq_n[2] = 1'b1;
      idle(2);
      bw(3'd2, 16'h07FF);
      idle(2);
      @(negedge clk); midi_out_empty = 1'b0;
      idle(3);

      chk_on = 0;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule